// File: doc/BRIEF.md
# Carrier Lock Detector Controller

This block decides whether a carrier tracking loop has locked onto its input. Every symbol, an end-of-symbol strobe delivers a signed phase error. The block adds the magnitude of that error to an accumulator that starts a programmable distance below overflow. At the same time it counts down a programmable number of symbols. If the integration counter runs out first, the average phase error was small enough and the loop is declared locked. If the accumulator overflows first, the loop is sent back to search. Either event closes the detection cycle, latches the sums, and starts a new cycle from the preload values.

The state drives two outputs. The first selects between the acquisition and tracking parameter sets for the loop filters. The second enables the frequency sweep into the lag path of the loop filter while searching. Alongside the phase error, a gain-error magnitude sum starts from zero each cycle as a data-quality estimate. It is flagged valid only for cycles spent entirely in tracking.

A stepped-acquisition option inserts a settling dwell of a programmable number of strobes after each cycle. A processor-control mode freezes the automatic decision and lets an external controller pick the state, while the sums are still gathered. The phase preload is normally set to 2^ACC_W minus (lock threshold × symbol count), scaled as the loop's phase units require, minus one.

Top module: `carrier_lock_det`

## Requirements
- R1: While `rst_n` is low, `track_sel`, `dump`, `gain_valid`, `phase_sum` and `gain_sum` are 0 and `sweep_en` is 1. On the first clock after release, the phase accumulator is loaded from `phase_preload` and the symbol counter from `count_preload`.
- R2: An accepted strobe adds the magnitude of `phase_err` to the phase accumulator. The code -2^(PE_W-1) counts as +2^(PE_W-1). The same strobe decrements the symbol counter by one. Cycles without a strobe change neither.
- R3: When the counter reaches zero on an accepted strobe without an accumulator carry, `track_sel` is 1 from the next cycle (automatic mode). A cycle spans `count_preload` strobes; a preload of 0 or 1 gives one strobe.
- R4: A carry out of the ACC_W-bit phase accumulator on an accepted strobe sets `track_sel` to 0 from the next cycle (automatic mode). This holds even when the counter reaches zero on the same strobe.
- R5: The strobe that ends a cycle raises `dump` for one cycle. The same strobe sets `phase_sum` to (preload + magnitudes, this strobe included) mod 2^ACC_W and reloads both preloads for the next cycle. `dump` is otherwise 0.
- R6: `sweep_en` is 1 exactly when `track_sel` is 0.
- R7: At `dump`, `gain_sum` is the sum of `gain_err` magnitudes over the cycle's accepted strobes, starting from zero. `gain_valid` is 1 if the state was tracking during that cycle. Both hold until the next `dump`.
- R8: With `step_mode` high at a cycle end, the next `dwell_preload` strobes are ignored: neither accumulator nor the counter changes.
- R9: With `cpu_mode` high, `track_sel` follows `cpu_track` one cycle later, and overflow or count-out leaves it unchanged. Accumulation, dumps and sums continue as in automatic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_strobe | input | 1 | End-of-symbol sample strobe |
| phase_err | input | PE_W | Signed phase error |
| gain_err | input | PE_W | Signed gain error |
| phase_preload | input | ACC_W | Phase accumulator start value |
| count_preload | input | CNT_W | Symbols per detection cycle |
| dwell_preload | input | DWELL_W | Strobes ignored after a cycle in stepped mode |
| step_mode | input | 1 | Stepped-acquisition dwell enable |
| cpu_mode | input | 1 | Processor-controlled state |
| cpu_track | input | 1 | State chosen by the processor (1 = tracking) |
| track_sel | output | 1 | 1 = tracking parameters / locked, 0 = acquisition / search |
| sweep_en | output | 1 | Frequency sweep enable |
| dump | output | 1 | One-cycle pulse at cycle end |
| phase_sum | output | ACC_W | Phase accumulator value at last cycle end |
| gain_sum | output | PE_W+CNT_W | Gain magnitude sum of last cycle |
| gain_valid | output | 1 | Last gain sum taken while tracking |

## Verification
A counter or accumulator that has drifted from its intended value shows at the ports at the next cycle end. The `dump` pulse then arrives on the wrong strobe, or `phase_sum` differs from preload plus magnitudes. That is at most one detection cycle late. A wrong decision in the state register shows one clock after the deciding strobe, as a wrong `track_sel`/`sweep_en` pair. The bench compares the outputs after every strobe and every idle cycle against a model. It covers a carry and a count-out landing on the same strobe, the most negative error code, one-symbol cycles, the full 1025-symbol cycle, dwell hold-off and processor override.

// File: rtl/cld_pkg.sv
`timescale 1ns/1ps
package cld_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_TRACK  = 1'b1
  } cld_state_e;
endpackage

// File: rtl/cld_mag_acc.sv
`timescale 1ns/1ps
// Magnitude accumulator with preload and carry-out detection.
module cld_mag_acc #(
  parameter int IN_W  = 8,
  parameter int ACC_W = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   add_en,
  input  logic [ACC_W-1:0]       load_val,
  input  logic signed [IN_W-1:0] sample,
  output logic [ACC_W-1:0]       sum_nxt,
  output logic                   carry
);
  localparam int PAD_W = ACC_W - IN_W;

  logic [IN_W-1:0]  raw;
  logic [IN_W-1:0]  mag;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  // Two's complement magnitude; the most negative code maps to 2^(IN_W-1).
  always_comb begin
    raw = sample;
    mag = raw[IN_W-1] ? (~raw + IN_W'(1)) : raw;
  end

  assign {carry, sum_nxt} = {1'b0, acc_q} + {{(PAD_W + 1){1'b0}}, mag};

  always_comb begin
    acc_d = acc_q;
    if (load)        acc_d = load_val;
    else if (add_en) acc_d = sum_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/cld_int_ctr.sv
`timescale 1ns/1ps
// Integration down-counter with settling dwell hold-off.
module cld_int_ctr #(
  parameter int CNT_W   = 11,
  parameter int DWELL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               dwell_arm,
  input  logic               strobe,
  input  logic [CNT_W-1:0]   count_pre,
  input  logic [DWELL_W-1:0] dwell_pre,
  output logic               take,
  output logic               last
);
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [DWELL_W-1:0] dwell_q, dwell_d;

  assign take = strobe && (dwell_q == '0);
  assign last = take && (cnt_q <= CNT_W'(1));

  always_comb begin
    cnt_d   = cnt_q;
    dwell_d = dwell_q;
    if (load) begin
      cnt_d   = count_pre;
      dwell_d = dwell_arm ? dwell_pre : '0;
    end else if (take) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else if (strobe) begin
      dwell_d = dwell_q - DWELL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      dwell_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      dwell_q <= dwell_d;
    end
  end
endmodule

// File: rtl/cld_ctrl.sv
`timescale 1ns/1ps
// Search / track decision.
module cld_ctrl
  import cld_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_evt,
  input  logic       zero_evt,
  input  logic       cpu_mode,
  input  logic       cpu_track,
  output cld_state_e state_q
);
  cld_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (cpu_mode)      state_d = cpu_track ? ST_TRACK : ST_SEARCH;
    else if (ovf_evt)  state_d = ST_SEARCH;
    else if (zero_evt) state_d = ST_TRACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SEARCH;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/carrier_lock_det.sv
`timescale 1ns/1ps
module carrier_lock_det
  import cld_pkg::*;
#(
  parameter int PE_W    = 8,
  parameter int ACC_W   = 18,
  parameter int CNT_W   = 11,
  parameter int DWELL_W = 4,
  localparam int GACC_W = PE_W + CNT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sym_strobe,
  input  logic signed [PE_W-1:0] phase_err,
  input  logic signed [PE_W-1:0] gain_err,
  input  logic [ACC_W-1:0]       phase_preload,
  input  logic [CNT_W-1:0]       count_preload,
  input  logic [DWELL_W-1:0]     dwell_preload,
  input  logic                   step_mode,
  input  logic                   cpu_mode,
  input  logic                   cpu_track,
  output logic                   track_sel,
  output logic                   sweep_en,
  output logic                   dump,
  output logic [ACC_W-1:0]       phase_sum,
  output logic [GACC_W-1:0]      gain_sum,
  output logic                   gain_valid
);
  logic              armed_q;
  logic              strb_ok, take, last;
  logic              carry_p, carry_g;
  logic [ACC_W-1:0]  psum_nxt;
  logic [GACC_W-1:0] gsum_nxt, gain_res;
  logic              ovf_evt, zero_evt, end_evt, reload;
  cld_state_e        state_q;

  logic              dump_q, dump_d;
  logic [ACC_W-1:0]  psum_q, psum_d;
  logic [GACC_W-1:0] gsum_q, gsum_d;
  logic              gval_q, gval_d;

  assign strb_ok  = sym_strobe && armed_q;
  // Overflow wins when both events land on the same strobe.
  assign ovf_evt  = take && carry_p;
  assign zero_evt = last && !carry_p;
  assign end_evt  = ovf_evt || last;
  assign reload   = !armed_q || end_evt;
  assign gain_res = carry_g ? '1 : gsum_nxt;

  cld_int_ctr #(.CNT_W(CNT_W), .DWELL_W(DWELL_W)) i_ctr (
    .clk(clk), .rst_n(rst_n), .load(reload), .dwell_arm(step_mode && armed_q),
    .strobe(strb_ok), .count_pre(count_preload), .dwell_pre(dwell_preload),
    .take(take), .last(last)
  );

  cld_mag_acc #(.IN_W(PE_W), .ACC_W(ACC_W)) i_phase_acc (
    .clk(clk), .rst_n(rst_n), .load(reload), .add_en(take && !end_evt),
    .load_val(phase_preload), .sample(phase_err),
    .sum_nxt(psum_nxt), .carry(carry_p)
  );

  cld_mag_acc #(.IN_W(PE_W), .ACC_W(GACC_W)) i_gain_acc (
    .clk(clk), .rst_n(rst_n), .load(reload), .add_en(take && !end_evt && !carry_g),
    .load_val('0), .sample(gain_err),
    .sum_nxt(gsum_nxt), .carry(carry_g)
  );

  cld_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .zero_evt(zero_evt),
    .cpu_mode(cpu_mode), .cpu_track(cpu_track), .state_q(state_q)
  );

  always_comb begin
    dump_d = end_evt;
    psum_d = psum_q;
    gsum_d = gsum_q;
    gval_d = gval_q;
    if (end_evt) begin
      psum_d = psum_nxt;
      gsum_d = gain_res;
      gval_d = (state_q == ST_TRACK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      dump_q  <= 1'b0;
      psum_q  <= '0;
      gsum_q  <= '0;
      gval_q  <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      dump_q  <= dump_d;
      psum_q  <= psum_d;
      gsum_q  <= gsum_d;
      gval_q  <= gval_d;
    end
  end

  assign track_sel  = (state_q == ST_TRACK);
  assign sweep_en   = (state_q == ST_SEARCH);
  assign dump       = dump_q;
  assign phase_sum  = psum_q;
  assign gain_sum   = gsum_q;
  assign gain_valid = gval_q;
endmodule

// File: rtl/cld_chk.sv
`timescale 1ns/1ps
module cld_chk #(
  parameter int ACC_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sym_strobe,
  input logic             cpu_mode,
  input logic             cpu_track,
  input logic             track_sel,
  input logic             sweep_en,
  input logic             dump,
  input logic             gain_valid,
  input logic [ACC_W-1:0] phase_sum,
  input logic             ovf_evt,
  input logic             zero_evt
);
  AST_SWEEP_IN_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_en != track_sel); // R6
  AST_DUMP_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_strobe |=> !dump); // R5
  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !dump |-> ($stable(phase_sum) && $stable(gain_valid))); // R7
  AST_OVERFLOW_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !cpu_mode) |=> !track_sel); // R4
  AST_COUNT_OUT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !cpu_mode) |=> track_sel); // R3
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_mode && !sym_strobe) |=> $stable(track_sel)); // R3
  AST_CPU_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mode |=> (track_sel == $past(cpu_track))); // R9
endmodule

bind carrier_lock_det cld_chk #(.ACC_W(ACC_W)) i_cld_chk (
  .clk(clk), .rst_n(rst_n), .sym_strobe(sym_strobe), .cpu_mode(cpu_mode),
  .cpu_track(cpu_track), .track_sel(track_sel), .sweep_en(sweep_en), .dump(dump),
  .gain_valid(gain_valid), .phase_sum(phase_sum), .ovf_evt(ovf_evt), .zero_evt(zero_evt)
);

// File: tb/test_carrier_lock_det.sv
`timescale 1ns/1ps
module test_carrier_lock_det;
  localparam int PE_W = 8, ACC_W = 18, CNT_W = 11, DWELL_W = 4;
  localparam int GACC_W = PE_W + CNT_W;
  localparam int FULL = 1 << ACC_W;

  logic clk = 1'b0;
  logic rst_n;
  logic sym_strobe;
  logic signed [PE_W-1:0] phase_err, gain_err;
  logic [ACC_W-1:0] phase_preload;
  logic [CNT_W-1:0] count_preload;
  logic [DWELL_W-1:0] dwell_preload;
  logic step_mode, cpu_mode, cpu_track;
  logic track_sel, sweep_en, dump, gain_valid;
  logic [ACC_W-1:0] phase_sum;
  logic [GACC_W-1:0] gain_sum;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_acc, m_cnt, m_gacc, m_dwell, m_state;

  always #4 clk = ~clk;

  carrier_lock_det #(.PE_W(PE_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .DWELL_W(DWELL_W)) i_carrier_lock_det (
    .clk(clk), .rst_n(rst_n), .sym_strobe(sym_strobe), .phase_err(phase_err),
    .gain_err(gain_err), .phase_preload(phase_preload), .count_preload(count_preload),
    .dwell_preload(dwell_preload), .step_mode(step_mode), .cpu_mode(cpu_mode),
    .cpu_track(cpu_track), .track_sel(track_sel), .sweep_en(sweep_en), .dump(dump),
    .phase_sum(phase_sum), .gain_sum(gain_sum), .gain_valid(gain_valid)
  );

  function automatic int mag(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_state();
    check("R3/R4", "track_sel", track_sel, m_state);
    check("R6", "sweep_en", sweep_en, !m_state);
  endtask

  task automatic do_reset(input int pre, input int cnt);
    phase_preload = ACC_W'(pre);
    count_preload = CNT_W'(cnt);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "track_sel", track_sel, 0);
    check("R1", "sweep_en", sweep_en, 1);
    check("R1", "dump", dump, 0);
    check("R1", "phase_sum", phase_sum, 0);
    check("R1", "gain_sum", gain_sum, 0);
    check("R1", "gain_valid", gain_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    m_acc = pre; m_cnt = cnt; m_gacc = 0; m_dwell = 0;
    m_state = cpu_mode ? int'(cpu_track) : 0;
  endtask

  task automatic step(input int pe, input int ge, input int gap);
    int s, g;
    bit ovf, zro, exp_dump;
    int exp_ps, exp_gs, exp_gv;
    phase_err = PE_W'(pe);
    gain_err  = PE_W'(ge);
    sym_strobe = 1'b1;
    @(negedge clk);
    sym_strobe = 1'b0;
    exp_dump = 0; exp_ps = 0; exp_gs = 0; exp_gv = 0;
    if (m_dwell > 0) begin
      m_dwell--;
    end else begin
      s = m_acc + mag(pe);
      g = m_gacc + mag(ge);
      ovf = (s >= FULL);
      zro = (m_cnt <= 1);
      if (ovf || zro) begin
        exp_dump = 1; exp_ps = s % FULL; exp_gs = g; exp_gv = m_state;
        if (!cpu_mode) m_state = ovf ? 0 : 1;
        m_acc = int'(phase_preload); m_cnt = int'(count_preload); m_gacc = 0;
        m_dwell = step_mode ? int'(dwell_preload) : 0;
      end else begin
        m_acc = s; m_cnt--; m_gacc = g;
      end
    end
    if (cpu_mode) m_state = int'(cpu_track);
    check("R5/R8", "dump", dump, exp_dump);
    check_state();
    if (exp_dump) begin
      check("R2/R5", "phase_sum", phase_sum, exp_ps);
      check("R7", "gain_sum", gain_sum, exp_gs);
      check("R7", "gain_valid", gain_valid, exp_gv);
    end
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      check("R2", "idle dump", dump, 0);
      check_state();
    end
  endtask

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; sym_strobe = 0; phase_err = 0; gain_err = 0;
    dwell_preload = 0; step_mode = 0; cpu_mode = 0; cpu_track = 0;
    phase_preload = 0; count_preload = 0;

    // Most negative phase error overflows at once (R2, R4)
    do_reset(FULL - 100, 4);
    step(-128, -128, 1);
    step(-128, 5, 0);

    // Carry and count-out on the same strobe: overflow wins (R4); one short: lock (R3)
    do_reset(FULL - 30, 3);
    step(10, 1, 0); step(-10, 2, 1); step(10, 3, 0);
    step(10, 1, 0); step(10, -4, 0); step(-9, 2, 2);
    step(10, 7, 0); step(10, 7, 0); step(10, 7, 0);
    step(1, 1, 0); step(1, 1, 0); step(1, 1, 0);
    step(2, 9, 0); step(2, 9, 0); step(2, 9, 0); // tracking cycle, gain valid (R7)

    // Random: small errors lock, large errors lose lock
    do_reset(FULL - 20 * 16, 16);
    for (int k = 0; k < 16 * 6; k++) step(rnd(-15, 15), rnd(-128, 127), rnd(0, 2));
    for (int k = 0; k < 16 * 4; k++) step(rnd(-127, 127), rnd(-128, 127), rnd(0, 2));

    // One-strobe cycles with preload 0 and 1 (R3)
    do_reset(FULL - 50, 0);
    step(3, 3, 0); step(60, 1, 0); step(4, 4, 1);
    do_reset(FULL - 50, 1);
    step(3, 3, 0); step(-60, 1, 0); step(4, 4, 0);

    // Stepped acquisition dwell (R8)
    step_mode = 1; dwell_preload = 3;
    do_reset(FULL - 40, 4);
    for (int k = 0; k < 60; k++) step(rnd(-20, 20), rnd(-50, 50), rnd(0, 1));
    step_mode = 0;
    for (int k = 0; k < 12; k++) step(rnd(-5, 5), rnd(-9, 9), 0);

    // Processor control (R9)
    do_reset(FULL - 40, 4);
    cpu_mode = 1; cpu_track = 1;
    @(negedge clk); m_state = 1; check_state();
    for (int k = 0; k < 12; k++) step(100, 5, 0);
    cpu_track = 0;
    @(negedge clk); m_state = 0; check_state();
    for (int k = 0; k < 8; k++) step(1, 2, 0);
    cpu_track = 1;
    @(negedge clk); m_state = 1;
    cpu_mode = 0;
    for (int k = 0; k < 8; k++) step(100, 3, 0);

    // Full 1025-symbol integration (R3)
    do_reset(FULL - 2 * 1025, 1025);
    for (int k = 0; k < 1025 * 2; k++) step((k % 2) ? 1 : -1, 1, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule